// File: doc/BRIEF.md
# I2C General Call Command Decoder

This block sits behind a byte-level I2C target receiver in a converter-style peripheral and handles broadcast (general call) transactions. The receiver reports bus START and STOP events and hands over each complete byte in the clock cycle of its acknowledge slot. The decoder keeps track of where each byte falls in the current transfer. It recognises an all-zero first byte as the general call address and acknowledges it. It then reads the byte that follows as a command.

Two commands are acted on. The soft-reset code returns the peripheral's configuration and data registers to their defaults and aborts a conversion that is running. The convert code rewrites the configuration with one-shot mode selected and starts a single conversion, keeping the gain and sample-rate fields as they were. Every decision and side effect is a registered output that appears one clock after the byte's acknowledge cycle. The peripheral uses these outputs to drive the SDA acknowledge, reset its registers, write its mode register and kick the converter.

Top module: `gcall_decoder`

## Requirements
- R1: After reset every output is low and mode_wdata_o is zero.
- R2: A first byte of 0x00 after START gives ack_vld_o=1 and ack_o=1 in the cycle after byte_valid_i. ack_vld_o is never high unless byte_valid_i was high in the previous cycle.
- R3: A non-zero first byte makes no acknowledge decision (ack_vld_o stays 0), and every later byte of that transfer is ignored until the next START.
- R4: A second byte equal to 0x06 is acknowledged and gives soft_rst_o as a one-cycle pulse in the cycle after its byte_valid_i.
- R5: conv_abort_o pulses together with soft_rst_o when conv_busy_i was high in the command byte's cycle, and stays low otherwise.
- R6: A second byte equal to 0x08 is acknowledged and gives one-cycle pulses on conv_start_o and mode_wr_o. mode_wdata_o equals cfg_i with bit 4 (1 = continuous, 0 = one-shot) cleared, and bits 7:5 and 3:0 (including rate [3:2] and gain [1:0]) unchanged.
- R7: A second byte of 0x00 is not acknowledged (ack_vld_o=1, ack_o=0) and causes no reset, conversion or mode write.
- R8: Any other second-byte value is answered with ack_o equal to the ACK_OTHER parameter (default 0) and has no side effects.
- R9: A START or STOP before the second byte, or in the same cycle as it, discards the pending general call. The byte in that cycle yields no decision or pulse.
- R10: Bytes after the second byte of a general call are ignored until the next START.
- R11: soft_rst_o and conv_start_o are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START (or repeated START) seen on the bus, one-cycle pulse |
| stop_i | input | 1 | STOP seen on the bus, one-cycle pulse |
| byte_valid_i | input | 1 | A received byte is complete, high in its acknowledge cycle |
| byte_i | input | 8 | Received byte, valid with byte_valid_i |
| cfg_i | input | 8 | Current configuration register contents |
| conv_busy_i | input | 1 | A conversion is in progress |
| ack_vld_o | output | 1 | An acknowledge decision is presented |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge, meaningful with ack_vld_o |
| soft_rst_o | output | 1 | Reset configuration and data registers to defaults |
| conv_abort_o | output | 1 | Abort the running conversion |
| conv_start_o | output | 1 | Start one conversion |
| mode_wr_o | output | 1 | Write mode_wdata_o into the configuration register |
| mode_wdata_o | output | 8 | Configuration value to write |

## Verification
The properties assume that byte_valid_i, start_i and stop_i come from a receiver that raises each of them for exactly one cycle per event. They also assume that cfg_i holds the live configuration in the byte's cycle. The discard property relies on START and STOP taking priority over a byte in the same cycle. The directed bench drives every event as a single-cycle pulse, sets cfg_i and conv_busy_i before the byte that samples them, and includes cases where START or STOP coincides with a command byte.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // position of the next expected byte within the current transfer
  typedef enum logic [1:0] {
    POS_IDLE = 2'd0,
    POS_ADDR = 2'd1,
    POS_CMD  = 2'd2,
    POS_DONE = 2'd3
  } pos_e;

  // classification of a general call command byte
  typedef enum logic [1:0] {
    GC_FORBID = 2'd0,
    GC_RESET  = 2'd1,
    GC_CONV   = 2'd2,
    GC_OTHER  = 2'd3
  } gc_cmd_e;

endpackage

// File: rtl/gcd_frame_track.sv
module gcd_frame_track
  import gcd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_i,
  output logic          addr_hit_o,
  output logic          cmd_slot_o
);

  pos_e pos_q, pos_d;
  logic bus_evt;
  logic byte_take;

  // bus events win over a byte landing in the same cycle
  assign bus_evt   = start_i | stop_i;
  assign byte_take = byte_valid_i & ~bus_evt;

  always_comb begin
    pos_d = pos_q;
    if (stop_i) begin
      pos_d = POS_IDLE;
    end else if (start_i) begin
      pos_d = POS_ADDR;
    end else if (byte_valid_i) begin
      case (pos_q)
        POS_ADDR: pos_d = (byte_i == '0) ? POS_CMD : POS_DONE;
        POS_CMD:  pos_d = POS_DONE;
        default:  pos_d = pos_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_IDLE;
    end else begin
      pos_q <= pos_d;
    end
  end

  assign addr_hit_o = byte_take & (pos_q == POS_ADDR) & (byte_i == '0);
  assign cmd_slot_o = byte_take & (pos_q == POS_CMD);

endmodule

// File: rtl/gcd_cmd_decode.sv
module gcd_cmd_decode
  import gcd_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] RST_CODE  = 'h06,
  parameter logic [DW-1:0] CONV_CODE = 'h08,
  parameter bit            ACK_OTHER = 1'b0
) (
  input  logic [DW-1:0] byte_i,
  output gc_cmd_e       cmd_o,
  output logic          ack_o
);

  always_comb begin
    if (byte_i == '0) begin
      cmd_o = GC_FORBID;
      ack_o = 1'b0;
    end else if (byte_i == RST_CODE) begin
      cmd_o = GC_RESET;
      ack_o = 1'b1;
    end else if (byte_i == CONV_CODE) begin
      cmd_o = GC_CONV;
      ack_o = 1'b1;
    end else begin
      cmd_o = GC_OTHER;
      ack_o = ACK_OTHER;
    end
  end

endmodule

// File: rtl/gcall_decoder.sv
module gcall_decoder
  import gcd_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            MODE_BIT  = 4,
  parameter logic [DW-1:0] RST_CODE  = 'h06,
  parameter logic [DW-1:0] CONV_CODE = 'h08,
  parameter bit            ACK_OTHER = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] cfg_i,
  input  logic          conv_busy_i,
  output logic          ack_vld_o,
  output logic          ack_o,
  output logic          soft_rst_o,
  output logic          conv_abort_o,
  output logic          conv_start_o,
  output logic          mode_wr_o,
  output logic [DW-1:0] mode_wdata_o
);

  localparam logic [DW-1:0] MODE_MASK = {{(DW-1){1'b0}}, 1'b1} << MODE_BIT;

  logic    addr_hit;
  logic    cmd_slot;
  gc_cmd_e cmd_kind;
  logic    cmd_ack;

  gcd_frame_track #(.DW(DW)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .addr_hit_o   (addr_hit),
    .cmd_slot_o   (cmd_slot)
  );

  gcd_cmd_decode #(
    .DW        (DW),
    .RST_CODE  (RST_CODE),
    .CONV_CODE (CONV_CODE),
    .ACK_OTHER (ACK_OTHER)
  ) u_dec (
    .byte_i (byte_i),
    .cmd_o  (cmd_kind),
    .ack_o  (cmd_ack)
  );

  logic          ack_vld_d, ack_d, rst_d, abort_d, conv_d;
  logic          wdata_en;
  logic [DW-1:0] wdata_d;
  logic          ack_vld_q, ack_q, rst_q, abort_q, conv_q, mwr_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    ack_vld_d = addr_hit | cmd_slot;
    ack_d     = addr_hit | (cmd_slot & cmd_ack);
    rst_d     = cmd_slot & (cmd_kind == GC_RESET);
    abort_d   = rst_d & conv_busy_i;
    conv_d    = cmd_slot & (cmd_kind == GC_CONV);
    wdata_en  = conv_d;
    wdata_d   = cfg_i & ~MODE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      rst_q     <= 1'b0;
      abort_q   <= 1'b0;
      conv_q    <= 1'b0;
      mwr_q     <= 1'b0;
    end else begin
      ack_vld_q <= ack_vld_d;
      ack_q     <= ack_d;
      rst_q     <= rst_d;
      abort_q   <= abort_d;
      conv_q    <= conv_d;
      mwr_q     <= conv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= wdata_d;
    end
  end

  assign ack_vld_o    = ack_vld_q;
  assign ack_o        = ack_q;
  assign soft_rst_o   = rst_q;
  assign conv_abort_o = abort_q;
  assign conv_start_o = conv_q;
  assign mode_wr_o    = mwr_q;
  assign mode_wdata_o = wdata_q;

endmodule

// File: rtl/gcd_checker.sv
module gcd_checker #(
  parameter int DW       = 8,
  parameter int MODE_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          stop_i,
  input logic          byte_valid_i,
  input logic [DW-1:0] cfg_i,
  input logic          ack_vld_o,
  input logic          ack_o,
  input logic          soft_rst_o,
  input logic          conv_abort_o,
  input logic          conv_start_o,
  input logic          mode_wr_o,
  input logic [DW-1:0] mode_wdata_o
);

  localparam logic [DW-1:0] KEEP_MASK = {{(DW-1){1'b0}}, 1'b1} << MODE_BIT;

  assert_decision_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid_i |=> !ack_vld_o);

  assert_rst_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (ack_vld_o && ack_o));

  assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  assert_abort_with_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |-> soft_rst_o);

  assert_conv_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> (mode_wr_o && ack_o && !mode_wdata_o[MODE_BIT]));

  assert_conv_keeps_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_o |-> ((mode_wdata_o | KEEP_MASK) == ($past(cfg_i) | KEEP_MASK)));

  assert_nack_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld_o && !ack_o) |-> (!soft_rst_o && !conv_start_o && !mode_wr_o));

  assert_bus_event_discards_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !(ack_vld_o || soft_rst_o || conv_start_o || mode_wr_o));

  assert_cmd_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_rst_o, conv_start_o}));

  assert_conv_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

endmodule

bind gcall_decoder gcd_checker #(.DW(DW), .MODE_BIT(MODE_BIT)) u_gcd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .byte_valid_i (byte_valid_i),
  .cfg_i        (cfg_i),
  .ack_vld_o    (ack_vld_o),
  .ack_o        (ack_o),
  .soft_rst_o   (soft_rst_o),
  .conv_abort_o (conv_abort_o),
  .conv_start_o (conv_start_o),
  .mode_wr_o    (mode_wr_o),
  .mode_wdata_o (mode_wdata_o)
);

// File: tb/gcall_decoder_bench.sv
`timescale 1ns/1ps
module gcall_decoder_bench;

  logic       clk;
  logic       rst_n;
  logic       start_i, stop_i, byte_valid_i, conv_busy_i;
  logic [7:0] byte_i, cfg_i;
  logic       ack_vld_o, ack_o, soft_rst_o, conv_abort_o, conv_start_o, mode_wr_o;
  logic [7:0] mode_wdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gcall_decoder u_gcall_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .cfg_i        (cfg_i),
    .conv_busy_i  (conv_busy_i),
    .ack_vld_o    (ack_vld_o),
    .ack_o        (ack_o),
    .soft_rst_o   (soft_rst_o),
    .conv_abort_o (conv_abort_o),
    .conv_start_o (conv_start_o),
    .mode_wr_o    (mode_wr_o),
    .mode_wdata_o (mode_wdata_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pack the single-bit outputs: {ack_vld, ack, rst, abort, conv, mwr}
  function automatic logic [5:0] outs();
    return {ack_vld_o, ack_o, soft_rst_o, conv_abort_o, conv_start_o, mode_wr_o};
  endfunction

  // drive one cycle of events; outputs of that cycle are visible at the next negedge
  task automatic drive(input logic st, input logic sp, input logic bv, input logic [7:0] b);
    @(negedge clk);
    start_i = st; stop_i = sp; byte_valid_i = bv; byte_i = b;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0; byte_valid_i = 1'b0; byte_i = 8'h00;
  endtask

  task automatic t_reset_state();
    check("R1", "outputs after reset", {26'd0, outs()}, 32'd0);
    check("R1", "mode_wdata after reset", {24'd0, mode_wdata_o}, 32'd0);
  endtask

  task automatic t_addr_ack();
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    check("R2", "general call address", {26'd0, outs()}, 32'b110000);
    @(negedge clk);
    check("R2", "no decision without byte", {31'd0, ack_vld_o}, 32'd0);
    drive(0, 1, 0, 8'h00);
  endtask

  task automatic t_reset_cmd(input logic busy);
    conv_busy_i = busy;
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(0, 0, 1, 8'h06);
    if (busy)
      check("R5", "reset while busy", {26'd0, outs()}, 32'b111100);
    else
      check("R4", "reset command", {26'd0, outs()}, 32'b111000);
    @(negedge clk);
    check("R11", "reset pulse single cycle", {31'd0, soft_rst_o}, 32'd0);
    drive(0, 1, 0, 8'h00);
    conv_busy_i = 1'b0;
  endtask

  task automatic t_conv_cmd(input logic [7:0] cfg, input logic [7:0] exp_w);
    cfg_i = cfg;
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(0, 0, 1, 8'h08);
    check("R6", "conversion command", {26'd0, outs()}, 32'b110011);
    check("R6", "one-shot write data", {24'd0, mode_wdata_o}, {24'd0, exp_w});
    @(negedge clk);
    check("R11", "conv pulse single cycle", {30'd0, conv_start_o, mode_wr_o}, 32'd0);
    drive(0, 1, 0, 8'h00);
  endtask

  task automatic t_second(input string req, input logic [7:0] b, input logic exp_ack);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(0, 0, 1, b);
    check(req, "second byte decision", {26'd0, outs()}, {26'd0, 1'b1, exp_ack, 4'b0000});
    drive(0, 1, 0, 8'h00);
  endtask

  task automatic t_non_gc();
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h90);
    check("R3", "non-zero address", {26'd0, outs()}, 32'd0);
    drive(0, 0, 1, 8'h06);
    check("R3", "byte after foreign address", {26'd0, outs()}, 32'd0);
    drive(0, 1, 0, 8'h00);
  endtask

  task automatic t_discard();
    // STOP between the bytes
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(0, 1, 0, 8'h00);
    drive(0, 0, 1, 8'h06);
    check("R9", "stop before command", {26'd0, outs()}, 32'd0);
    // repeated START between the bytes: next byte is an address again
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h08);
    check("R9", "start before command", {26'd0, outs()}, 32'd0);
    drive(0, 1, 0, 8'h00);
    // STOP coinciding with the command byte
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(0, 1, 1, 8'h06);
    check("R9", "stop with command", {26'd0, outs()}, 32'd0);
    // START coinciding with the command byte
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(1, 0, 1, 8'h08);
    check("R9", "start with command", {26'd0, outs()}, 32'd0);
    drive(0, 1, 0, 8'h00);
  endtask

  task automatic t_third();
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 1, 8'h00);
    drive(0, 0, 1, 8'h55);
    drive(0, 0, 1, 8'h06);
    check("R10", "third byte reset code", {26'd0, outs()}, 32'd0);
    drive(0, 0, 1, 8'h08);
    check("R10", "fourth byte conv code", {26'd0, outs()}, 32'd0);
    drive(0, 1, 0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0; stop_i = 1'b0; byte_valid_i = 1'b0; byte_i = 8'h00;
    cfg_i = 8'h00; conv_busy_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_addr_ack();
    t_reset_cmd(1'b0);
    t_reset_cmd(1'b1);
    t_conv_cmd(8'b1001_1110, 8'b1000_1110);
    t_conv_cmd(8'b0000_0101, 8'b0000_0101);
    t_second("R7", 8'h00, 1'b0);
    t_second("R8", 8'h55, 1'b0);
    t_second("R8", 8'h07, 1'b0);
    t_non_gc();
    t_discard();
    t_third();
    t_reset_cmd(1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule